// File: doc/BRIEF.md
# RTC Seconds Trim Adjuster

This block sits between a one-pulse-per-second tick source and a seconds counter. It trims the long-term rate of the counter. Every (period + 1) raw ticks it makes one correction: either it drops one tick, which slows the count, or it adds one extra tick, which speeds it up. The resulting trim is 1e9 / (period + 1) parts per billion.

One 32-bit configuration word controls the block. Bits 18:0 hold the period. Bits 20:19 hold the direction code. Bit 23 is the enable flag. A write to this word also restarts the period count. When the block is not correcting, each raw tick is passed through with one cycle of latency.

Top module: `rtc_sec_trim`

## Requirements
- R1: After reset, `tick_out` is 0 and the configuration is cleared, so a raw tick is forwarded unchanged.
- R2: When bit 23 of the configuration word is 0, every raw tick at `tick_in` produces exactly one `tick_out` pulse one cycle later, whatever the period and direction fields hold.
- R3: When bit 23 is 1 and the direction code in bits 20:19 is 0 or 1, no correction is applied and ticks pass through as in R2.
- R4: When bit 23 is 1 and the code is 2 (swallow), the raw tick numbered k after the last write is suppressed whenever k is a multiple of P+1, where P is bits 18:0. All other ticks pass one cycle later.
- R5: When bit 23 is 1 and the code is 3 (insert), the tick numbered k with k a multiple of P+1 produces `tick_out` pulses one cycle and two cycles after `tick_in`. All other ticks produce a single pulse.
- R6: A configuration write clears the period count. A raw tick in the same cycle as the write is forwarded uncorrected and is not counted.
- R7: With P equal to 0, every raw tick is corrected: it is swallowed under code 2 and doubled under code 3.
- R8: Bits 31:24 and 22:21 of the configuration word are ignored.
- R9: Raw ticks must be separated by at least one idle cycle. Under that rule, no two output pulses from different raw ticks merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| tick_in | input | 1 | Raw one-cycle seconds pulse |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: period in 18:0, direction in 20:19, enable in 23 |
| tick_out | output | 1 | Corrected seconds pulse stream |

## Verification
The tick stream is tried under several configurations:
- Enable cleared with live fields, and the two inert codes with enable set. These show that the correction depends on both the enable flag and the upper direction bit.
- Swallow and insert with small periods, over two full periods. These show that the correction lands on the right tick number and repeats.
- A period of zero, which tells apart an off-by-one in the wrap compare.
- A rewrite in the middle of a period, and a write coinciding with a tick, which prove the count restarts and that the coincident tick is not counted.
- A word with stray bits set in the unused positions, which shows those bits are ignored.

// File: rtl/rtc_sec_trim_pkg.sv
package rtc_sec_trim_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned PERIOD_W  = 19;
  localparam int unsigned DIR_LSB   = PERIOD_W;
  localparam int unsigned ENABLE_BIT = 23;

  typedef enum logic [1:0] {
    TRIM_NONE0   = 2'd0,
    TRIM_NONE1   = 2'd1,
    TRIM_SWALLOW = 2'd2,
    TRIM_INSERT  = 2'd3
  } trim_dir_e;

  typedef struct packed {
    logic                enable;
    trim_dir_e           dir;
    logic [PERIOD_W-1:0] period;
  } trim_cfg_t;

  function automatic trim_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    trim_cfg_t c;
    c.enable = w[ENABLE_BIT];
    c.dir    = trim_dir_e'(w[DIR_LSB+1:DIR_LSB]);
    c.period = w[PERIOD_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
  import rtc_sec_trim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CFG_W-1:0]    wdata,
  output logic                active,
  output logic                is_insert,
  output logic [PERIOD_W-1:0] period
);
  trim_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = unpack_cfg(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // Only codes with the upper direction bit set correct anything.
  assign active    = cfg_q.enable && cfg_q.dir[1];
  assign is_insert = (cfg_q.dir == TRIM_INSERT);
  assign period    = cfg_q.period;

  p_inert_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[DIR_LSB+1]) |=> !active);
endmodule

// File: rtl/trim_period_ctr.sv
module trim_period_ctr
  import rtc_sec_trim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                clr,
  input  logic                active,
  input  logic [PERIOD_W-1:0] period,
  output logic                hit
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;
  logic                at_end;

  assign at_end = (cnt_q == period);
  assign hit    = active && tick && !clr && at_end;
  assign cnt_en = clr || !active || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !active)  cnt_d = '0;
    else if (tick)       cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= period));
  p_write_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/trim_tick_shaper.sv
module trim_tick_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic is_insert,
  output logic tick_out
);
  logic drop, add;
  logic out_q, out_d;
  logic extra_q, extra_d;

  assign drop = hit && !is_insert;
  assign add  = hit &&  is_insert;

  always_comb begin
    out_d   = (tick && !drop) || extra_q;
    extra_d = tick && add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      extra_q <= extra_d;
    end
  end

  assign tick_out = out_q;

  p_swallow_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && drop) |=> !tick_out);
  p_insert_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && add) |=> tick_out ##1 tick_out);
  p_plain_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit) |=> tick_out);
endmodule

// File: rtl/rtc_sec_trim.sv
module rtc_sec_trim
  import rtc_sec_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             tick_out
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                active, is_insert, hit;
  logic [PERIOD_W-1:0] period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trim_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .wdata(cfg_wdata),
    .active(active), .is_insert(is_insert), .period(period)
  );

  trim_period_ctr u_ctr (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_in), .clr(cfg_we),
    .active(active), .period(period), .hit(hit)
  );

  trim_tick_shaper u_shape (
    .clk(clk), .rst_n(rst_int_n), .tick(tick_in), .hit(hit),
    .is_insert(is_insert), .tick_out(tick_out)
  );

  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    tick_in |=> !tick_in);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> !tick_out);
endmodule

// File: tb/rtc_sec_trim_test.sv
module rtc_sec_trim_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_in;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        tick_out;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rtc_sec_trim uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .tick_out(tick_out)
  );

  task automatic check(input string req, input logic act, input logic exp, input int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s tick %0d: actual %0b expected %0b", req, idx, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit [1:0] dir, input int per);
    return (32'(en) << 23) | (32'(dir) << 19) | (32'(per) & 32'h7FFFF);
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // One raw tick; returns output one and two cycles after it.
  task automatic send_tick(input bit with_write, input logic [31:0] w,
                           output logic o1, output logic o2);
    @(negedge clk); tick_in = 1'b1;
    if (with_write) begin cfg_we = 1'b1; cfg_wdata = w; end
    @(negedge clk); tick_in = 1'b0; cfg_we = 1'b0; o1 = tick_out;
    @(negedge clk); o2 = tick_out;
    @(negedge clk);
  endtask

  // n ticks after a write; expected pattern computed from period and code.
  task automatic run_seq(input string req, input logic [31:0] w, input bit corr,
                         input bit ins, input int per, input int n);
    logic o1, o2;
    write_cfg(w);
    for (int k = 1; k <= n; k++) begin
      bit hitk;
      hitk = corr && ((k % (per + 1)) == 0);
      send_tick(1'b0, '0, o1, o2);
      check(req, o1, !(hitk && !ins), k);
      check(req, o2, hitk && ins, k);
    end
  endtask

  task automatic t_reset;
    logic o1, o2;
    check("R1", tick_out, 1'b0, 0);
    send_tick(1'b0, '0, o1, o2);
    check("R1", o1, 1'b1, 1);
    check("R1", o2, 1'b0, 1);
  endtask

  task automatic t_restart;
    logic o1, o2;
    write_cfg(mk(1, 2'd2, 3));
    send_tick(1'b0, '0, o1, o2);
    send_tick(1'b0, '0, o1, o2);
    // mid-period rewrite: count restarts, fourth tick after it is dropped
    run_seq("R6", mk(1, 2'd2, 3), 1, 0, 3, 4);
    // write coincident with a tick: forwarded, not counted
    send_tick(1'b1, mk(1, 2'd2, 3), o1, o2);
    check("R6", o1, 1'b1, 0);
    for (int k = 1; k <= 4; k++) begin
      send_tick(1'b0, '0, o1, o2);
      check("R6", o1, k != 4, k);
    end
  endtask

  initial begin
    tick_in = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_seq("R2", mk(0, 2'd2, 0), 0, 0, 0, 3);
    run_seq("R2", mk(0, 2'd3, 1), 0, 0, 1, 3);
    run_seq("R3", mk(1, 2'd1, 0), 0, 0, 0, 3);
    run_seq("R3", mk(1, 2'd0, 0), 0, 0, 0, 3);
    run_seq("R4", mk(1, 2'd2, 3), 1, 0, 3, 8);
    run_seq("R5", mk(1, 2'd3, 2), 1, 1, 2, 6);
    t_restart();
    run_seq("R7", mk(1, 2'd2, 0), 1, 0, 0, 3);
    run_seq("R7", mk(1, 2'd3, 0), 1, 1, 0, 3);
    run_seq("R8", mk(1, 2'd2, 1) | 32'hFF60_0000, 1, 0, 1, 4);
    run_seq("R9", mk(1, 2'd3, 1), 1, 1, 1, 4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule